// File: doc/BRIEF.md
# Biphase Input Lock Monitor

This block decides whether a biphase-mark receiver is following its input at the nominal rate, which is one quarter of the system clock. It takes the already-sampled input line and a one-cycle strobe from the decoder that marks each detected block preamble. From these it keeps three pieces of evidence. The first is how long the line has gone without a transition. The second is a signed count of transitions that land off the expected half-cell grid of an internal divide-by-4 phase counter. The third is how long it has been since the last block preamble.

The block has two states. It leaves the unlocked state only on a preamble strobe, and only while the line is active and the drift count is in range. It falls back when the line goes quiet, when the drift grows too large, or when preambles stop arriving. The gating enable lets downstream logic force its serial data, preamble, control-bit and audio outputs low whenever the receiver is not locked.

Top module: `lm_lock_monitor`

## Requirements
- R1: While reset is held and after its release, the lock flag and the gating enable are low and the unlock flag is high, until a lock is acquired.
- R2: A preamble strobe sampled in the unlocked state sets the lock flag on the next clock edge, but only if an input transition occurred within the last IDLE_LIM clocks and the drift count before the strobe is within ±DRIFT_LIM. Otherwise the strobe leaves the block unlocked.
- R3: If the input holds its level on IDLE_LIM consecutive clock edges (default 32), the block is unlocked at that edge. After IDLE_LIM-1 quiet edges a held lock remains.
- R4: A 2-bit phase counter starts at 0 on reset release and advances by one each clock. An input transition seen at phase 1 adds one to the drift count. One seen at phase 3 subtracts one. Transitions at phases 0 and 2 leave the count unchanged. A count whose magnitude exceeds DRIFT_LIM (default 32) unlocks the block.
- R5: A preamble strobe sets the drift count to zero in the same edge, so off-grid transitions before and after a preamble do not add up.
- R6: While locked, if PRE_GAP clocks pass with no preamble strobe, the block unlocks.
- R7: After a drift loss, the first preamble strobe only clears the count and the block stays unlocked. A later strobe with the count in range locks it again.
- R8: The gating enable always equals the lock flag, and the unlock flag is always its complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_smp | input | 1 | Biphase input, already sampled on clk |
| blk_pre | input | 1 | One-cycle strobe for a detected block preamble |
| lock_flag | output | 1 | High while locked |
| unlock_flag | output | 1 | High while not locked |
| out_gate_en | output | 1 | Enable for the downstream data, preamble and control outputs |

## Verification
Most internal faults show at the ports within one clock, because every loss condition feeds the registered state directly. A drift count that is off by even one step moves the exact edge at which 33 late or early transitions drop the lock. An idle counter that clears or saturates wrongly moves the quiet-line drop away from the 32nd quiet edge. A preamble counter that is off moves the drop away from the PRE_GAP boundary. A drift count that is not cleared by a preamble shows up only later, as a spurious drop after the second group of off-grid edges, so the bench pairs such groups around a strobe. A reference model compares all three outputs on every clock of a long random run.

// File: rtl/lm_pkg.sv
package lm_pkg;
    // Width of the divide-by-4 timebase phase.
    localparam int LM_PH_W = 2;
    localparam logic [LM_PH_W-1:0] LM_PH_LATE  = 2'd1;
    localparam logic [LM_PH_W-1:0] LM_PH_EARLY = 2'd3;

    typedef enum logic {
        LM_LOST   = 1'b0,
        LM_LOCKED = 1'b1
    } lm_state_e;
endpackage

// File: rtl/lm_activity.sv
module lm_activity #(
    parameter int IDLE_LIM = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_o,
    output logic silent_o
);
    localparam int IW = $clog2(IDLE_LIM + 1);
    localparam logic [IW-1:0] IDLE_SAT = IW'(IDLE_LIM);

    typedef struct packed {
        logic          prev;
        logic [IW-1:0] idle;
    } act_t;

    act_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.prev = din;
        edge_o   = din ^ s_q.prev;
        if (edge_o) begin
            s_d.idle = '0;
        end else if (s_q.idle != IDLE_SAT) begin
            s_d.idle = s_q.idle + IW'(1);
        end
        silent_o = (s_d.idle == IDLE_SAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.prev <= 1'b0;
            s_q.idle <= IDLE_SAT;
        end else begin
            s_q <= s_d;
        end
    end

    AST_SILENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        silent_o |-> !edge_o);  // R3
endmodule

// File: rtl/lm_drift.sv
module lm_drift
    import lm_pkg::*;
#(
    parameter int DRIFT_LIM = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic pre_i,
    output logic bad_o,
    output logic ok_o
);
    localparam int DW = $clog2(DRIFT_LIM + 2) + 1;
    localparam logic signed [DW-1:0] D_LIM   = DW'(DRIFT_LIM);
    localparam logic signed [DW-1:0] D_SAT_P = DW'(DRIFT_LIM + 1);
    localparam logic signed [DW-1:0] D_SAT_N = -D_SAT_P;
    localparam logic signed [DW-1:0] D_LIM_N = -D_LIM;

    typedef struct packed {
        logic [LM_PH_W-1:0] ph;
        logic [DW-1:0]      drift;
    } drf_t;

    drf_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ph = s_q.ph + LM_PH_W'(1);
        if (pre_i) begin
            s_d.drift = '0;
        end else if (edge_i && (s_q.ph == LM_PH_LATE) &&
                     ($signed(s_q.drift) != D_SAT_P)) begin
            s_d.drift = s_q.drift + DW'(1);
        end else if (edge_i && (s_q.ph == LM_PH_EARLY) &&
                     ($signed(s_q.drift) != D_SAT_N)) begin
            s_d.drift = s_q.drift - DW'(1);
        end
        bad_o = ($signed(s_d.drift) > D_LIM) || ($signed(s_d.drift) < D_LIM_N);
        ok_o  = ($signed(s_q.drift) <= D_LIM) && ($signed(s_q.drift) >= D_LIM_N);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph    <= '0;
            s_q.drift <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_DRIFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |=> (s_q.drift == '0));  // R5
    AST_DRIFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_i && !pre_i) |=> $stable(s_q.drift));  // R4
endmodule

// File: rtl/lm_pregap.sv
module lm_pregap #(
    parameter int PRE_GAP = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pre_i,
    output logic gap_to_o
);
    localparam int GW = $clog2(PRE_GAP + 1);
    localparam logic [GW-1:0] GAP_SAT = GW'(PRE_GAP);

    typedef struct packed {
        logic [GW-1:0] gap;
    } gap_t;

    gap_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (pre_i) begin
            s_d.gap = '0;
        end else if (s_q.gap != GAP_SAT) begin
            s_d.gap = s_q.gap + GW'(1);
        end
        gap_to_o = (s_d.gap == GAP_SAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.gap <= GAP_SAT;
        end else begin
            s_q <= s_d;
        end
    end

    AST_GAP_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        pre_i |-> !gap_to_o);  // R6
endmodule

// File: rtl/lm_lock_monitor.sv
module lm_lock_monitor
    import lm_pkg::*;
#(
    parameter int IDLE_LIM  = 32,
    parameter int DRIFT_LIM = 32,
    parameter int PRE_GAP   = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_smp,
    input  logic blk_pre,
    output logic lock_flag,
    output logic unlock_flag,
    output logic out_gate_en
);
    typedef struct packed {
        lm_state_e st;
    } top_t;

    top_t s_d, s_q;

    logic edge_w;
    logic silent_w;
    logic drift_bad_w;
    logic drift_ok_w;
    logic gap_to_w;

    lm_activity #(.IDLE_LIM(IDLE_LIM)) u_act (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (in_smp),
        .edge_o  (edge_w),
        .silent_o(silent_w)
    );

    lm_drift #(.DRIFT_LIM(DRIFT_LIM)) u_drift (
        .clk   (clk),
        .rst_n (rst_n),
        .edge_i(edge_w),
        .pre_i (blk_pre),
        .bad_o (drift_bad_w),
        .ok_o  (drift_ok_w)
    );

    lm_pregap #(.PRE_GAP(PRE_GAP)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .pre_i   (blk_pre),
        .gap_to_o(gap_to_w)
    );

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            LM_LOST: begin
                if (blk_pre && !silent_w && drift_ok_w) begin
                    s_d.st = LM_LOCKED;
                end
            end
            LM_LOCKED: begin
                if (silent_w || drift_bad_w || gap_to_w) begin
                    s_d.st = LM_LOST;
                end
            end
            default: s_d.st = LM_LOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st <= LM_LOST;
        end else begin
            s_q <= s_d;
        end
    end

    assign lock_flag   = (s_q.st == LM_LOCKED);
    assign unlock_flag = (s_q.st == LM_LOST);
    assign out_gate_en = (s_q.st == LM_LOCKED);

    AST_LOCK_ON_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_flag) |-> $past(blk_pre));  // R2
    AST_SILENCE_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        silent_w |=> unlock_flag);  // R3
    AST_DRIFT_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        drift_bad_w |=> unlock_flag);  // R4
    AST_GAP_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_flag && gap_to_w) |=> unlock_flag);  // R6
    AST_RELOCK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_flag && blk_pre && !drift_ok_w) |=> unlock_flag);  // R7
endmodule

// File: tb/test_lm_lock_monitor.sv
module test_lm_lock_monitor;
    localparam int IDLE = 32;
    localparam int DLIM = 32;
    localparam int GAP  = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_in = 1'b0;
    logic pre_stb = 1'b0;
    logic lock_flag, unlock_flag, out_gate_en;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_req = "R1";
    bit mon_en = 1'b0;

    // reference model state
    int  m_ph = 0, m_idle = IDLE, m_drift = 0, m_gap = GAP;
    bit  m_prev = 1'b0, m_lock = 1'b0;

    always #2 clk = ~clk;

    lm_lock_monitor #(.IDLE_LIM(IDLE), .DRIFT_LIM(DLIM), .PRE_GAP(GAP)) i_lm_lock_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_smp     (bit_in),
        .blk_pre    (pre_stb),
        .lock_flag  (lock_flag),
        .unlock_flag(unlock_flag),
        .out_gate_en(out_gate_en)
    );

    function automatic int sat_inc(int v, int lim);
        return (v < lim) ? v + 1 : lim;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev = 1'b0; m_idle = IDLE; m_drift = 0; m_gap = GAP; m_ph = 0; m_lock = 1'b0;
        end else begin
            bit e;
            int n_idle, n_drift, n_gap;
            bit silent, bad;
            e = (bit_in != m_prev);
            m_prev = bit_in;
            n_idle = e ? 0 : sat_inc(m_idle, IDLE);
            n_drift = m_drift;
            if (pre_stb) n_drift = 0;
            else if (e && m_ph == 1 && m_drift < DLIM + 1) n_drift = m_drift + 1;
            else if (e && m_ph == 3 && m_drift > -(DLIM + 1)) n_drift = m_drift - 1;
            n_gap = pre_stb ? 0 : sat_inc(m_gap, GAP);
            silent = (n_idle >= IDLE);
            bad = (n_drift > DLIM) || (n_drift < -DLIM);
            if (!m_lock) m_lock = pre_stb && !silent && (m_drift <= DLIM) && (m_drift >= -DLIM);
            else m_lock = !(silent || bad || (n_gap >= GAP));
            m_idle = n_idle; m_drift = n_drift; m_gap = n_gap;
            m_ph = (m_ph + 1) % 4;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // per-cycle comparison against the model (R8 relation included)
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            chk(cur_req, lock_flag, m_lock);
            chk("R8", out_gate_en, lock_flag);
            chk("R8", unlock_flag, !lock_flag);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step(input logic b, input logic p);
        bit_in = b; pre_stb = p;
        @(negedge clk);
    endtask

    task automatic even_run(input int n);
        for (int i = 0; i < n; i++) step((m_ph % 2 == 0) ? ~bit_in : bit_in, 1'b0);
    endtask

    task automatic off_edges(input int k, input int ph);
        int c = 0;
        while (c < k) begin
            if (m_ph == ph) begin step(~bit_in, 1'b0); c++; end
            else step(bit_in, 1'b0);
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        chk("R1", lock_flag, 0); chk("R1", unlock_flag, 1); chk("R1", out_gate_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        chk("R1", unlock_flag, 1);

        cur_req = "R2";
        step(bit_in, 1'b1);              // no activity yet: no lock
        chk("R2", lock_flag, 0);
        even_run(20);
        step(bit_in, 1'b1);
        chk("R2", lock_flag, 1); chk("R8", out_gate_en, 1);

        cur_req = "R3";
        step(~bit_in, 1'b0);
        for (int i = 0; i < IDLE - 1; i++) step(bit_in, 1'b0);
        chk("R3", lock_flag, 1);
        step(bit_in, 1'b0);
        chk("R3", unlock_flag, 1);

        cur_req = "R4";
        even_run(8); step(bit_in, 1'b1);
        chk("R4", lock_flag, 1);
        off_edges(DLIM, 1);
        chk("R4", lock_flag, 1);
        off_edges(1, 1);
        chk("R4", unlock_flag, 1);

        cur_req = "R7";
        even_run(8); step(bit_in, 1'b1);
        chk("R7", lock_flag, 0);
        even_run(8); step(bit_in, 1'b1);
        chk("R7", lock_flag, 1);

        cur_req = "R5";
        off_edges(30, 1); step(bit_in, 1'b1); off_edges(30, 1);
        chk("R5", lock_flag, 1);

        cur_req = "R6";
        even_run(4); step(bit_in, 1'b1);
        even_run(GAP - 1);
        chk("R6", lock_flag, 1);
        even_run(1);
        chk("R6", unlock_flag, 1);

        cur_req = "R4";
        even_run(8); step(bit_in, 1'b1);
        chk("R4", lock_flag, 1);
        off_edges(DLIM, 3);
        chk("R4", lock_flag, 1);
        off_edges(1, 3);
        chk("R4", unlock_flag, 1);

        cur_req = "R2";
        for (int seg = 0; seg < 100; seg++) begin
            int mode = $urandom_range(0, 5);
            int len  = $urandom_range(50, 350);
            for (int i = 0; i < len; i++) begin
                logic b = bit_in;
                logic p = ($urandom_range(0, 127) == 0);
                if (mode <= 3) begin
                    if (m_ph % 2 == 0 && $urandom_range(0, 3) != 0) b = ~bit_in;
                    if (m_ph % 2 == 1 && $urandom_range(0, 15) == 0) b = ~bit_in;
                end else if (mode == 4) begin
                    if ($urandom_range(0, 1) == 0) b = ~bit_in;
                end
                step(b, p);
            end
        end

        mon_en = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule